// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the status byte of a serial memory and rules on every write request the command decoder raises. The serial front end hands it single-cycle strobes: write-enable and write-disable commands that have completed, a completed status-write command together with its data byte, and a pulse marking the start of each command. It also receives the current write address of an array write and the level of the active-low write-protect pin. In return it gives the byte a status read returns, a flag saying whether a status write may go ahead, and a flag saying whether the array byte at the current address may be written.

Protection has two modes. In software mode the two block-protect bits choose which part of the array is locked, and a status write can change them. Hardware mode is entered at the start of a command when the write-protect pin is low and the write-disable bit of the status byte is 0. Only a later command start that sees the pin high leaves it. While the unit is in hardware mode, status writes are refused, so the block-protect bits cannot change. The pin is sampled only at command starts, so the mode stays fixed for the whole of a command. A two-state machine holds the mode: SOFT (software protection) and HARD (hardware protection). The transition SOFT_TO_HARD fires on a command start with the pin low and the write-disable bit 0. The transition HARD_TO_SOFT fires on a command start with the pin high. On any other cycle the machine holds its state.

Top module: `wp_guard`

## Requirements
- R1: The write-enable latch is status bit 1. A write-enable strobe sets it and a write-disable strobe clears it. When both strobes arrive in the same cycle, the disable wins. The new value shows on the status byte in the cycle after the strobe.
- R2: After reset the status byte reads 0x00 and the unit is in software mode.
- R3: While the write-enable latch is 0, `stat_wr_ok` and `arr_wr_ok` are both 0, and a status-write strobe leaves the status byte unchanged.
- R4: On a `cs_start` pulse, the unit moves from SOFT to HARD if `wp_n` is 0 and the write-disable bit is 0. It moves from HARD back to SOFT only on a `cs_start` pulse with `wp_n` at 1. A pulse with `wp_n` at 0 while the write-disable bit is 1 leaves the unit in SOFT.
- R5: In HARD, `stat_wr_ok` is 0 and a status-write strobe leaves every status bit unchanged, the block-protect bits included.
- R6: In SOFT with the write-enable latch set, a status-write strobe loads the write-disable bit from data bit 7 and the block-protect bits from data bits 3:2. Data bits 6:4 and 1:0 are ignored. `stat_wr_ok` is 1 in exactly this condition.
- R7: The status byte layout is: bit 7 write-disable, bit 3 block-protect high, bit 2 block-protect low, bit 1 write-enable latch. Bits 6:4 and 0 always read 0.
- R8: The block-protect code selects the locked part of the array. With code 00 nothing is locked. With 01 the top quarter is locked (the two address MSBs are 11). With 10 the top half is locked (address MSB is 1). With 11 the whole array is locked. `arr_wr_ok` is 1 only when the latch is set and the address is not locked.
- R9: A status write does not clear the write-enable latch.
- R10: Changes of `wp_n` between `cs_start` pulses have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| cs_start | input | 1 | One-cycle pulse at the start of each command |
| wp_n | input | 1 | Write-protect pin level, active low |
| cmd_wren | input | 1 | Completed write-enable command |
| cmd_wrdi | input | 1 | Completed write-disable command |
| cmd_wrsr | input | 1 | Completed status-write command |
| wrsr_data | input | 8 | Data byte of the status write |
| wr_addr | input | ADDR_W | Array address of the byte being written |
| status_byte | output | 8 | Status byte returned by a status read |
| stat_wr_ok | output | 1 | A status write would be accepted |
| arr_wr_ok | output | 1 | An array write at `wr_addr` would be accepted |

## Verification
The bench builds the unit with `ADDR_W` = 4, which gives a 16-byte array. At that size it can apply every address under every block-protect code, both with the latch set and with it clear, so each quarter and half boundary is hit exactly. It also applies all 256 status-write data bytes in software mode. It then walks every pin and write-disable combination through both mode transitions, drives a status write while in hardware mode, and applies a reset taken from hardware mode.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    typedef enum logic [0:0] {
        SOFT = 1'b0,
        HARD = 1'b1
    } prot_mode_e;

    localparam int SRWD_BIT = 7;
    localparam int BPH_BIT  = 3;
    localparam int BPL_BIT  = 2;
    localparam int WEL_BIT  = 1;

endpackage

// File: rtl/wpg_mode_fsm.sv
module wpg_mode_fsm
    import wpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_start,
    input  logic       wp_n,
    input  logic       srwd,
    output prot_mode_e mode,
    output logic       hw_lock
);

    prot_mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SOFT;
        else        state_q <= state_d;
    end

    // next state: pin level only counts at a command start
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SOFT: if (cs_start && !wp_n && !srwd) state_d = HARD; // SOFT_TO_HARD
            HARD: if (cs_start && wp_n)           state_d = SOFT; // HARD_TO_SOFT
            default: state_d = SOFT;
        endcase
    end

    // outputs
    always_comb begin
        mode    = state_q;
        hw_lock = 1'b0;
        unique case (state_q)
            SOFT: hw_lock = 1'b0;
            HARD: hw_lock = 1'b1;
            default: hw_lock = 1'b1;
        endcase
    end

endmodule

// File: rtl/wpg_status_reg.sv
module wpg_status_reg
    import wpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wren,
    input  logic       cmd_wrdi,
    input  logic       cmd_wrsr,
    input  logic [7:0] wrsr_data,
    input  logic       hw_lock,
    output logic       wel,
    output logic       srwd,
    output logic [1:0] bp,
    output logic       sr_write_ok
);

    logic unused_data_bits;
    assign unused_data_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};

    assign sr_write_ok = wel && !hw_lock;

    // write-enable latch; disable has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wel <= 1'b0;
        else if (cmd_wrdi) wel <= 1'b0;
        else if (cmd_wren) wel <= 1'b1;
    end

    // protection fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srwd <= 1'b0;
            bp   <= 2'b00;
        end else if (cmd_wrsr && sr_write_ok) begin
            srwd <= wrsr_data[SRWD_BIT];
            bp   <= wrsr_data[BPH_BIT:BPL_BIT];
        end
    end

endmodule

// File: rtl/wpg_block_decode.sv
module wpg_block_decode #(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    output logic              locked
);

    localparam int TOP = ADDR_W - 1;

    logic in_top_half, in_top_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign in_top_half    = addr[TOP];
            assign in_top_quarter = addr[TOP] & addr[TOP-1];
        end else begin : g_narrow
            assign in_top_half    = addr[0];
            assign in_top_quarter = addr[0];
        end
    endgenerate

    always_comb begin
        unique case (bp)
            2'b00: locked = 1'b0;
            2'b01: locked = in_top_quarter;
            2'b10: locked = in_top_half;
            2'b11: locked = 1'b1;
            default: locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_start,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        status_byte,
    output logic              stat_wr_ok,
    output logic              arr_wr_ok
);

    prot_mode_e mode_q;
    logic       hw_lock, wel, srwd, locked;
    logic [1:0] bp;

    wpg_mode_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_start (cs_start),
        .wp_n     (wp_n),
        .srwd     (srwd),
        .mode     (mode_q),
        .hw_lock  (hw_lock)
    );

    wpg_status_reg i_sr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wren    (cmd_wren),
        .cmd_wrdi    (cmd_wrdi),
        .cmd_wrsr    (cmd_wrsr),
        .wrsr_data   (wrsr_data),
        .hw_lock     (hw_lock),
        .wel         (wel),
        .srwd        (srwd),
        .bp          (bp),
        .sr_write_ok (stat_wr_ok)
    );

    wpg_block_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr   (wr_addr),
        .bp     (bp),
        .locked (locked)
    );

    always_comb begin
        status_byte          = 8'h00;
        status_byte[SRWD_BIT] = srwd;
        status_byte[BPH_BIT]  = bp[1];
        status_byte[BPL_BIT]  = bp[0];
        status_byte[WEL_BIT]  = wel;
    end

    assign arr_wr_ok = wel && !locked;

endmodule

// File: rtl/wpg_checker.sv
module wpg_checker
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_start,
    input logic              wp_n,
    input logic              cmd_wren,
    input logic              cmd_wrdi,
    input logic              cmd_wrsr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        status_byte,
    input logic              stat_wr_ok,
    input logic              arr_wr_ok,
    input prot_mode_e        mode
);

    AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !cmd_wrdi) |=> status_byte[1]); // R1
    AST_WEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrdi |=> !status_byte[1]); // R1
    AST_STAT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_ok |-> status_byte[1]); // R3
    AST_ARR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok |-> status_byte[1]); // R3
    AST_HARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HARD && !(cs_start && wp_n)) |=> mode == HARD); // R4
    AST_HARD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HARD && !cmd_wren && !cmd_wrdi) |=> $stable(status_byte)); // R5
    AST_HARD_NO_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HARD) |-> !stat_wr_ok); // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[6:4] == 3'b000 && !status_byte[0])); // R7
    AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !arr_wr_ok); // R8
    AST_WRSR_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !cmd_wrdi && status_byte[1]) |=> status_byte[1]); // R9

    logic unused_addr;
    assign unused_addr = ^wr_addr;

endmodule

bind wp_guard wpg_checker #(.ADDR_W(ADDR_W)) i_wpg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_start    (cs_start),
    .wp_n        (wp_n),
    .cmd_wren    (cmd_wren),
    .cmd_wrdi    (cmd_wrdi),
    .cmd_wrsr    (cmd_wrsr),
    .wr_addr     (wr_addr),
    .status_byte (status_byte),
    .stat_wr_ok  (stat_wr_ok),
    .arr_wr_ok   (arr_wr_ok),
    .mode        (mode_q)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int NADDR      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_start = 1'b0;
    logic              wp_n = 1'b1;
    logic              cmd_wren = 1'b0;
    logic              cmd_wrdi = 1'b0;
    logic              cmd_wrsr = 1'b0;
    logic [7:0]        wrsr_data = 8'h00;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        status_byte;
    logic              stat_wr_ok, arr_wr_ok;

    int vectors = 0;
    int fails   = 0;

    // expected state, from the requirements
    logic       e_wel = 1'b0, e_srwd = 1'b0, e_hard = 1'b0;
    logic [1:0] e_bp = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_guard #(.ADDR_W(ADDR_W)) i_wp_guard (
        .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .wrsr_data(wrsr_data), .wr_addr(wr_addr),
        .status_byte(status_byte), .stat_wr_ok(stat_wr_ok), .arr_wr_ok(arr_wr_ok)
    );

    function automatic logic exp_locked(input logic [1:0] bp, input int a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= (NADDR * 3) / 4;
            2'b10:   return a >= NADDR / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req);
        logic [7:0] es;
        logic       eso, eao;
        es  = {e_srwd, 3'b000, e_bp, e_wel, 1'b0};
        eso = e_wel && !e_hard;
        eao = e_wel && !exp_locked(e_bp, int'(wr_addr));
        vectors++;
        if (status_byte !== es || stat_wr_ok !== eso || arr_wr_ok !== eao) begin
            fails++;
            $display("FAIL %s: status=%h sok=%b aok=%b expected status=%h sok=%b aok=%b (addr %0d)",
                     req, status_byte, stat_wr_ok, arr_wr_ok, es, eso, eao, wr_addr);
        end
    endtask

    // one strobe cycle; model updated alongside, checked after the edge
    task automatic strobe(input logic wren, input logic wrdi, input logic wrsr,
                          input logic [7:0] d, input logic csf, input logic wp,
                          input string req);
        @(negedge clk);
        cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr;
        wrsr_data = d; cs_start = csf; wp_n = wp;
        if (wrsr && e_wel && !e_hard) begin
            e_srwd = d[7];
            e_bp   = d[3:2];
        end
        if (wrdi)      e_wel = 1'b0;
        else if (wren) e_wel = 1'b1;
        if (csf) begin
            if (e_hard && wp)                   e_hard = 1'b0;
            else if (!e_hard && !wp && !e_srwd) e_hard = 1'b1;
        end
        @(negedge clk);
        cmd_wren = 1'b0; cmd_wrdi = 1'b0; cmd_wrsr = 1'b0; cs_start = 1'b0;
        check(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        e_wel = 1'b0; e_srwd = 1'b0; e_bp = 2'b00; e_hard = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        do_reset();

        // R3: no latch, nothing writable
        strobe(0, 0, 1, 8'h8C, 0, 1, "R3");
        for (int a = 0; a < NADDR; a++) begin
            wr_addr = a[ADDR_W-1:0]; #1; check("R3");
        end

        // R1: set, clear, simultaneous
        strobe(1, 0, 0, 8'h00, 0, 1, "R1");
        strobe(0, 1, 0, 8'h00, 0, 1, "R1");
        strobe(1, 0, 0, 8'h00, 0, 1, "R1");
        strobe(1, 1, 0, 8'h00, 0, 1, "R1");

        // R6, R7, R9: every data byte in software mode
        strobe(1, 0, 0, 8'h00, 0, 1, "R1");
        for (int d = 0; d < 256; d++)
            strobe(0, 0, 1, d[7:0], 0, 1, "R6_R7_R9");

        // R8: every code against every address, latch set and clear
        for (int b = 0; b < 4; b++) begin
            strobe(1, 0, 0, 8'h00, 0, 1, "R1");
            strobe(0, 0, 1, {4'b0000, b[1:0], 2'b00}, 0, 1, "R6");
            for (int a = 0; a < NADDR; a++) begin
                wr_addr = a[ADDR_W-1:0]; #1; check("R8");
            end
            strobe(0, 1, 0, 8'h00, 0, 1, "R1");
            for (int a = 0; a < NADDR; a++) begin
                wr_addr = a[ADDR_W-1:0]; #1; check("R3");
            end
        end

        // R4: pin low with write-disable set stays soft
        strobe(1, 0, 0, 8'h00, 0, 1, "R1");
        strobe(0, 0, 1, 8'h84, 0, 1, "R6");
        strobe(0, 0, 0, 8'h00, 1, 0, "R4");
        // clear write-disable, set code 10, then enter hardware mode
        strobe(0, 0, 1, 8'h08, 0, 0, "R6");
        strobe(0, 0, 0, 8'h00, 1, 0, "R4");
        // R5: status write refused
        strobe(0, 0, 1, 8'h8C, 0, 0, "R5");
        strobe(0, 0, 1, 8'h00, 0, 0, "R5");
        // R10: pin high without command start keeps hardware mode
        strobe(0, 0, 0, 8'h00, 0, 1, "R10");
        strobe(0, 0, 1, 8'h04, 0, 1, "R10");
        strobe(0, 0, 0, 8'h00, 1, 0, "R4");
        // latch toggles still allowed in hardware mode
        strobe(0, 1, 0, 8'h00, 0, 0, "R1");
        strobe(1, 0, 0, 8'h00, 0, 0, "R1");
        // leave on command start with pin high
        strobe(0, 0, 0, 8'h00, 1, 1, "R4");
        strobe(0, 0, 1, 8'h0C, 0, 1, "R6");
        // R10: pin low between starts does not lock
        strobe(0, 0, 0, 8'h00, 0, 0, "R10");
        strobe(0, 0, 1, 8'h04, 0, 0, "R10");

        // re-enter hardware mode, then reset out of it
        strobe(0, 0, 0, 8'h00, 1, 0, "R4");
        do_reset();
        strobe(1, 0, 0, 8'h00, 0, 1, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule